// File: doc/BRIEF.md
# Line-Aligned Range Maintenance Splitter

This block sits in front of a cache maintenance command queue. It accepts one request at a time, made of a start address, an end address and an operation code. It turns the request into a stream of range commands. Every range command covers whole cache lines and is never larger than a configured chunk limit.

Before chunking, the start address is rounded down to a line boundary and the length is rounded up to whole lines. When the distance from the aligned start to the end is so large that rounding it up would wrap the address space, the block issues one whole-cache command in place of the ranges. Every request ends with a sync command. The request side and the command side each use a valid/ready handshake. A busy output reports that a request is still being issued.

Top module: `range_maint_splitter`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `req_ready` is 1 and `cmd_valid` is 0.
- R2: A request is taken only while the block is idle. From the cycle after acceptance until the sync command is taken, `req_ready` is 0 and `busy` is 1. A request presented in that window has no effect on the commands issued.
- R3: The first range command starts at the request start with its low log2(LINE_BYTES) bits cleared. Each later range command starts where the previous one ended.
- R4: The range commands' sizes add up to (end − aligned start), computed modulo 2^ADDR_W and rounded up to a multiple of LINE_BYTES.
- R5: Each range command has size min(remaining, CHUNK_LIMIT − LINE_BYTES). The size is non-zero and a multiple of LINE_BYTES.
- R6: If (end − aligned start) mod 2^ADDR_W is at least 2^ADDR_W − LINE_BYTES, exactly one whole-cache command carrying the request's operation code is issued. It has start 0 and size 0, and a sync follows it.
- R7: A sync command follows the last range command or the whole-cache command. Once the sync is taken, the block is idle again in the next cycle.
- R8: If end equals the aligned start, no range command is issued and the sync is the only command.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, every command output holds its value into the next cycle.
- R10: `cmd_kind` encodes 0 for range, 1 for whole-cache and 2 for sync. Range and whole-cache commands carry the request's `req_op` unchanged. A sync carries op 0, start 0 and size 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | OP_W | Maintenance operation code |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Address one past the range |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Queue takes the command |
| cmd_kind | output | 2 | 0 range, 1 whole cache, 2 sync |
| cmd_op | output | OP_W | Operation code of the command |
| cmd_start | output | ADDR_W | Range start (0 for whole cache and sync) |
| cmd_size | output | ADDR_W | Range size in bytes (0 for whole cache and sync) |
| busy | output | 1 | A request is being issued |

## Verification
Wrong cursor or remaining-length state shows up at the command port on the next command taken. It appears as a start that does not join the previous chunk, an oversized or zero chunk, or a total size that differs from the rounded length. A wrong state transition shows as a missing or extra sync, a whole-cache command where ranges were due, or `req_ready` not returning one cycle after the sync is taken. The bench compares every command against a model built from the requirements, including lengths just below and at the wrap threshold, exact chunk multiples and zero-length requests. It also checks output stability on every stalled cycle.

// File: rtl/rms_pkg.sv
package rms_pkg;
  typedef enum logic [1:0] {
    KIND_RANGE = 2'd0,
    KIND_ALL   = 2'd1,
    KIND_SYNC  = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RANGE = 2'd1,
    ST_ALL   = 2'd2,
    ST_SYNC  = 2'd3
  } split_state_e;
endpackage

// File: rtl/rms_align.sv
// Rounds the start down to a line, measures the span and flags wrap-around.
module rms_align #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] astart_o,
  output logic [ADDR_W-1:0] asize_o,
  output logic              whole_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~LOW_MASK; // equals -LINE_BYTES

  logic [ADDR_W-1:0] span;

  always_comb begin
    astart_o = start_i & LINE_MASK;
    span     = end_i - astart_o;
    whole_o  = (span >= LINE_MASK);
    asize_o  = (span + LOW_MASK) & LINE_MASK;
  end
endmodule

// File: rtl/rms_chunk.sv
// Picks the next chunk from the remaining length.
module rms_chunk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_CHUNK = 4194240
) (
  input  logic [ADDR_W-1:0] rem_i,
  output logic [ADDR_W-1:0] chunk_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] MAXC = ADDR_W'(MAX_CHUNK);

  always_comb begin
    last_o  = (rem_i <= MAXC);
    chunk_o = last_o ? rem_i : MAXC;
  end
endmodule

// File: rtl/range_maint_splitter.sv
module range_maint_splitter #(
  parameter int ADDR_W      = 32,
  parameter int OP_W        = 4,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_LIMIT = 4194304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ADDR_W-1:0] cmd_start,
  output logic [ADDR_W-1:0] cmd_size,
  output logic              busy
);
  import rms_pkg::*;

  localparam int MAX_CHUNK = CHUNK_LIMIT - LINE_BYTES;
  localparam int LINE_LOG  = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] MAXC = ADDR_W'(MAX_CHUNK);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  // datapath helpers
  logic [ADDR_W-1:0] al_start, al_size, chunk;
  logic              al_whole, chunk_last;

  rms_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .start_i (req_start),
    .end_i   (req_end),
    .astart_o(al_start),
    .asize_o (al_size),
    .whole_o (al_whole)
  );

  split_state_e      st_q, st_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [ADDR_W-1:0] cur_q, cur_d, rem_q, rem_d;

  rms_chunk #(.ADDR_W(ADDR_W), .MAX_CHUNK(MAX_CHUNK)) u_chunk (
    .rem_i  (rem_q),
    .chunk_o(chunk),
    .last_o (chunk_last)
  );

  logic accept, fire, upd_en;

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign cmd_valid = busy;
  assign accept    = req_valid && req_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign upd_en    = accept || fire;

  // next state
  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    cur_d = cur_q;
    rem_d = rem_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          op_d  = req_op;
          cur_d = al_start;
          rem_d = al_size;
          if (al_whole)           st_d = ST_ALL;
          else if (al_size == '0) st_d = ST_SYNC;
          else                    st_d = ST_RANGE;
        end
      end
      ST_RANGE: begin
        if (fire) begin
          cur_d = cur_q + chunk;
          rem_d = rem_q - chunk;
          if (chunk_last) st_d = ST_SYNC;
        end
      end
      ST_ALL:  if (fire) st_d = ST_SYNC;
      ST_SYNC: if (fire) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      cur_q <= '0;
      rem_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      op_q  <= op_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
    end
  end

  // command outputs
  always_comb begin
    cmd_kind  = KIND_SYNC;
    cmd_op    = '0;
    cmd_start = '0;
    cmd_size  = '0;
    unique case (st_q)
      ST_RANGE: begin
        cmd_kind  = KIND_RANGE;
        cmd_op    = op_q;
        cmd_start = cur_q;
        cmd_size  = chunk;
      end
      ST_ALL: begin
        cmd_kind = KIND_ALL;
        cmd_op   = op_q;
      end
      default: ;
    endcase
  end

  // assertions
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_op)
                                   && $stable(cmd_start) && $stable(cmd_size)));

  a_r5_chunk_bounds: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_kind == KIND_RANGE) |->
      (cmd_size != '0 && cmd_size <= MAXC && cmd_size[LINE_LOG-1:0] == '0));

  a_r3_start_aligned: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_kind == KIND_RANGE) |-> (cmd_start[LINE_LOG-1:0] == '0));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_ready) |=> (busy && !req_ready));

  a_r7_idle_after_sync: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_ready && cmd_kind == KIND_SYNC) |=> (req_ready && !cmd_valid));
endmodule

// File: tb/range_maint_splitter_tb.sv
module range_maint_splitter_tb;
  localparam int AW = 16;
  localparam int OW = 4;
  localparam int LB = 16;
  localparam int CL = 128;
  localparam int MC = CL - LB; // 112

  typedef struct packed {
    logic [1:0]    k;
    logic [OW-1:0] op;
    logic [AW-1:0] s;
    logic [AW-1:0] z;
  } cmd_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, cmd_valid, cmd_ready, busy;
  logic [OW-1:0] req_op, cmd_op;
  logic [AW-1:0] req_start, req_end, cmd_start, cmd_size;
  logic [1:0]    cmd_kind;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  range_maint_splitter #(.ADDR_W(AW), .OP_W(OW), .LINE_BYTES(LB), .CHUNK_LIMIT(CL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_start(req_start), .req_end(req_end),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_op(cmd_op), .cmd_start(cmd_start), .cmd_size(cmd_size), .busy(busy)
  );

  cmd_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] align_dn(input logic [AW-1:0] a);
    return a & ~AW'(LB - 1);
  endfunction

  // expected command list from the requirements
  task automatic build(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic [OW-1:0] op);
    logic [AW-1:0] a, sz, c;
    int unsigned   left;
    exp_q.delete();
    a  = align_dn(s);
    sz = e - a;
    if (int'(sz) >= (1 << AW) - LB) begin
      exp_q.push_back('{2'd1, op, '0, '0});
    end else begin
      left = (int'(sz) + LB - 1) / LB * LB;
      while (left != 0) begin
        c = AW'((left > MC) ? MC : left);
        exp_q.push_back('{2'd0, op, a, c});
        a    = a + c;
        left = left - int'(c);
      end
    end
    exp_q.push_back('{2'd2, '0, '0, '0});
  endtask

  task automatic run_req(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic [OW-1:0] op,
                         input bit all_ready, input bit poke, input bit expect_only_sync);
    cmd_t held, got, want;
    bit   have_hold = 0;
    bit   rdy;
    bit   first_seen = 0;
    logic [AW-1:0] first_start = '0;
    int   total = 0, n_seen = 0;
    int   exp_total;
    bit   is_range;
    build(s, e, op);
    is_range  = (exp_q[0].k == 2'd0);
    exp_total = 0;
    foreach (exp_q[i]) exp_total += int'(exp_q[i].z);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_start = s; req_end = e; req_op = op;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R2 busy after accept", {busy, req_ready}, 2'b10);
    if (poke) begin
      req_valid = 1'b1; req_start = ~s; req_end = s; req_op = ~op;
    end
    while (exp_q.size() > 0) begin
      if (have_hold) begin
        got = '{cmd_kind, cmd_op, cmd_start, cmd_size};
        chk(cmd_valid && got == held, "R9 stall hold", 64'(got), 64'(held));
        have_hold = 0;
      end
      if (poke) chk(!req_ready, "R2 not ready while busy", req_ready, 1'b0);
      rdy = all_ready ? 1'b1 : ($urandom % 3 != 0);
      cmd_ready = rdy;
      if (!cmd_valid) begin
        chk(1'b0, "R7 command missing", cmd_valid, 1'b1);
        void'(exp_q.pop_front());
      end else begin
        got = '{cmd_kind, cmd_op, cmd_start, cmd_size};
        if (rdy) begin
          want = exp_q.pop_front();
          n_seen++;
          if (want.k == 2'd0) begin
            if (!first_seen) begin first_seen = 1; first_start = got.s; end
            total += int'(got.z);
            chk(got == want, "R5 range chunk", 64'(got), 64'(want));
          end else if (want.k == 2'd1)
            chk(got == want, "R6 whole-cache command", 64'(got), 64'(want));
          else
            chk(got == want, "R10 sync command", 64'(got), 64'(want));
        end else begin
          held = got; have_hold = 1;
        end
      end
      @(negedge clk);
      if (exp_q.size() == 0) req_valid = 1'b0;
    end
    cmd_ready = 1'b0;
    req_valid = 1'b0;
    chk(req_ready && !cmd_valid && !busy, "R7 idle after sync", {req_ready, cmd_valid, busy}, 3'b100);
    if (is_range) begin
      chk(first_start == align_dn(s), "R3 first start aligned", first_start, align_dn(s));
      chk(total == exp_total, "R4 total rounded size", total, exp_total);
    end
    if (expect_only_sync) chk(n_seen == 1, "R8 only sync", n_seen, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; cmd_ready = 1'b0;
    req_op = '0; req_start = '0; req_end = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !busy, "R1 reset idle", {req_ready, cmd_valid, busy}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !busy, "R1 idle after release", {req_ready, cmd_valid, busy}, 3'b100);

    // directed corners
    run_req(16'h0105, 16'h0100, 4'h1, 1, 0, 1);   // R8 end == aligned start
    run_req(16'h0100, 16'h0101, 4'h2, 1, 0, 0);   // R4 one byte -> one line
    run_req(16'h0100, 16'h0170, 4'h3, 0, 0, 0);   // R5 exactly one max chunk
    run_req(16'h0100, 16'h01E0, 4'h3, 0, 0, 0);   // R5 two max chunks
    run_req(16'h0107, 16'h0250, 4'h9, 0, 1, 0);   // R2 request while busy ignored
    run_req(16'h0020, 16'h0010, 4'h2, 0, 0, 0);   // R6 span == -line
    run_req(16'h0020, 16'h0011, 4'h1, 1, 0, 0);   // R6 span just above threshold
    run_req(16'h0020, 16'h000F, 4'h5, 1, 0, 0);   // R6 below threshold: long range
    run_req(16'hFFF3, 16'h0030, 4'h0, 0, 0, 0);   // R3 range wrapping address zero

    // random
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] s;
      s = AW'($urandom);
      run_req(s, s + AW'($urandom % 700), OW'($urandom), bit'($urandom % 2), bit'(i % 5 == 0), 0);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule